// File: doc/BRIEF.md
# Masked Multi-Slot Target Address Matcher

This block decides whether an address byte seen on a two-wire serial bus selects the local target device. It keeps a small table of address slots. Each slot holds a 7-bit address, a general-call enable and a per-bit don't-care mask. Software fills the table through a simple register write port and can read it back through a registered read port.

The protocol engine strobes each received address byte into the matcher. One clock later the matcher presents a set of held results: whether the byte hit, which slot won, and whether the hit was a general call. It also returns the exact 7-bit address that was received, so software can tell which member of a masked address range was used, and it passes the read/write direction bit through. The protocol engine, acknowledge driving and data movement live outside this block.

Top module: `amatch_top`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data` into slot `wr_idx`. With `wr_is_mask` low the write goes to the address register; with `wr_is_mask` high it goes to the mask register. The value selected by `rd_is_mask`/`rd_idx` shows on `rd_data` one clock later.
- R2: Bit 0 of every mask register always reads as 0, whatever value is written to it.
- R3: For a received byte, its bits 7:1 are the 7-bit address. Slot i hits when each of those bits equals bit k of the slot's address register (k = 7..1), except where bit k of the slot's mask register is 1, which makes that bit a don't-care. Example: address register 0x20 with mask 0x06 accepts 7-bit addresses 0x10 to 0x13.
- R4: When several slots hit, `match_idx` reports the lowest-numbered one.
- R5: A received 7-bit address of 0 is a general call. It matches only when bit 0 of some slot's address register is 1. In that case `gen_call` is 1, `match` is 1 and `match_idx` is the lowest slot with that bit set. Otherwise the byte misses.
- R6: On a match, `hit_addr` holds the received 7-bit address in bits 7:1 with bit 0 at 0. On a miss it is 0x00, `match_idx` is 0 and `gen_call` is 0.
- R7: Bit 0 of the received byte takes no part in matching. It is reported on `rw_dir`.
- R8: A slot whose address field (bits 7:1) is zero never hits a non-zero address, whatever its mask.
- R9: The outputs change only at the clock edge where `rx_valid` is sampled high. They are valid from the next cycle and are held while `rx_valid` is low. Reset drives all of them to 0.
- R10: Reset clears every address and mask register to 0, so no address and no general call matches until software configures a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_is_mask | input | 1 | 1 selects a mask register, 0 selects an address register |
| wr_idx | input | IDX_W | Slot number to write |
| wr_data | input | 8 | Write data |
| rd_is_mask | input | 1 | Read selector: 1 selects mask, 0 selects address |
| rd_idx | input | IDX_W | Slot number to read |
| rd_data | output | 8 | Registered read data |
| rx_valid | input | 1 | Received address byte strobe |
| rx_byte | input | 8 | Received address byte: address in bits 7:1, direction in bit 0 |
| match | output | 1 | The byte selected this device |
| match_idx | output | IDX_W | Winning slot |
| gen_call | output | 1 | The match was a general call |
| hit_addr | output | 8 | Received 7-bit address in bits 7:1 on a match, else 0 |
| rw_dir | output | 1 | Direction bit of the last strobed byte |

## Verification
On every cycle, assertions check these properties: the results are held between strobes, the direction bit follows the strobed byte, a general call always comes with a match, miss results are all-zero, and mask read-back has bit 0 clear. Some behaviour can only be shown by the bench's scenarios. These are the masked comparison itself, lowest-slot priority among overlapping slots, the zero-address slot that serves general calls only, and the reset-cleared table. To show them, the bench sweeps all 256 received bytes against several slot tables and compares each result with arithmetic computed from the requirements.

// File: rtl/amatch_pkg.sv
package amatch_pkg;
  localparam int ADDR_BITS = 7;

  typedef struct packed {
    logic [ADDR_BITS-1:0] addr;
    logic                 gc_en;
    logic [ADDR_BITS-1:0] dc_mask;
  } slot_cfg_t;
endpackage

// File: rtl/amatch_cfg_regs.sv
module amatch_cfg_regs
  import amatch_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_is_mask,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [7:0]                   wr_data,
  input  logic                         rd_is_mask,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [7:0]                   rd_data,
  output slot_cfg_t [NUM_SLOTS-1:0]    cfg
);
  logic [7:0]           addr_q [NUM_SLOTS];
  logic [ADDR_BITS-1:0] mask_q [NUM_SLOTS];

  // R1 / R10: configuration storage, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        addr_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (wr_en && (int'(wr_idx) < NUM_SLOTS)) begin
      if (wr_is_mask) mask_q[wr_idx] <= wr_data[7:1];
      else            addr_q[wr_idx] <= wr_data;
    end
  end

  // R1 / R2: registered read-back; mask bit 0 is reserved
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rd_idx) < NUM_SLOTS) begin
      rd_data <= rd_is_mask ? {mask_q[rd_idx], 1'b0} : addr_q[rd_idx];
    end else begin
      rd_data <= '0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cfg
      assign cfg[g].addr    = addr_q[g][7:1];
      assign cfg[g].gc_en   = addr_q[g][0];
      assign cfg[g].dc_mask = mask_q[g];
    end
  endgenerate

  p_mask_lsb_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_is_mask |=> (rd_data[0] == 1'b0));
endmodule

// File: rtl/amatch_slot_cmp.sv
module amatch_slot_cmp
  import amatch_pkg::*;
(
  input  slot_cfg_t            cfg,
  input  logic [ADDR_BITS-1:0] rx_addr,
  output logic                 addr_hit,
  output logic                 gc_hit
);
  logic                 rx_is_zero;
  logic                 slot_is_zero;
  logic [ADDR_BITS-1:0] diff;

  always_comb begin
    rx_is_zero   = (rx_addr == '0);
    slot_is_zero = (cfg.addr == '0);
    diff         = (rx_addr ^ cfg.addr) & ~cfg.dc_mask;
    // R3 masked compare; R8 zero-address slot never hits a real address
    addr_hit     = !rx_is_zero && !slot_is_zero && (diff == '0);
    // R5 general call
    gc_hit       = rx_is_zero && cfg.gc_en;
  end
endmodule

// File: rtl/amatch_resolve.sv
module amatch_resolve
  import amatch_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic [NUM_SLOTS-1:0] addr_hits,
  input  logic [NUM_SLOTS-1:0] gc_hits,
  output logic                 match,
  output logic [IDX_W-1:0]     match_idx,
  output logic                 gen_call,
  output logic [7:0]           hit_addr,
  output logic                 rw_dir
);
  logic             any_addr, any_gc, any_hit;
  logic [IDX_W-1:0] addr_win, gc_win;

  // R4: lowest-numbered slot wins
  always_comb begin
    addr_win = '0;
    gc_win   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (addr_hits[i]) addr_win = IDX_W'(i);
      if (gc_hits[i])   gc_win   = IDX_W'(i);
    end
    any_addr = |addr_hits;
    any_gc   = |gc_hits;
    any_hit  = any_addr | any_gc;
  end

  // R6 / R7 / R9: results captured on the strobe and held
  always_ff @(posedge clk) begin
    if (rst) begin
      match     <= 1'b0;
      match_idx <= '0;
      gen_call  <= 1'b0;
      hit_addr  <= '0;
      rw_dir    <= 1'b0;
    end else if (rx_valid) begin
      match     <= any_hit;
      gen_call  <= any_gc;
      match_idx <= any_addr ? addr_win : (any_gc ? gc_win : '0);
      hit_addr  <= any_hit ? {rx_byte[7:1], 1'b0} : 8'h00;
      rw_dir    <= rx_byte[0];
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(match) && $stable(match_idx) && $stable(gen_call)
                   && $stable(hit_addr) && $stable(rw_dir)));

  p_dir_follow_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (rw_dir == $past(rx_byte[0])));

  p_gc_is_match_r5: assert property (@(posedge clk) disable iff (rst)
    gen_call |-> (match && hit_addr == 8'h00));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !match |-> (hit_addr == 8'h00 && match_idx == '0 && !gen_call));

  p_hit_lsb_r6: assert property (@(posedge clk) disable iff (rst)
    match |-> (hit_addr[0] == 1'b0));
endmodule

// File: rtl/amatch_top.sv
module amatch_top
  import amatch_pkg::*;
#(
  parameter int  NUM_SLOTS = 4,
  localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_is_mask,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             rd_is_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             match,
  output logic [IDX_W-1:0] match_idx,
  output logic             gen_call,
  output logic [7:0]       hit_addr,
  output logic             rw_dir
);
  slot_cfg_t [NUM_SLOTS-1:0] cfg;
  logic [NUM_SLOTS-1:0]      addr_hits;
  logic [NUM_SLOTS-1:0]      gc_hits;

  amatch_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_is_mask (wr_is_mask),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_is_mask (rd_is_mask),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .cfg        (cfg)
  );

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      amatch_slot_cmp u_cmp (
        .cfg      (cfg[g]),
        .rx_addr  (rx_byte[7:1]),
        .addr_hit (addr_hits[g]),
        .gc_hit   (gc_hits[g])
      );
    end
  endgenerate

  amatch_resolve #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_resolve (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .addr_hits (addr_hits),
    .gc_hits   (gc_hits),
    .match     (match),
    .match_idx (match_idx),
    .gen_call  (gen_call),
    .hit_addr  (hit_addr),
    .rw_dir    (rw_dir)
  );
endmodule

// File: tb/tb_amatch_top.sv
module tb_amatch_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_is_mask = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [7:0] wr_data = '0, rx_byte = '0;
  logic rd_is_mask = 1'b0, rx_valid = 1'b0;
  logic [7:0] rd_data, hit_addr;
  logic match, gen_call, rw_dir;
  logic [IW-1:0] match_idx;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] addr_m [NS];
  logic [7:0] mask_m [NS];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  amatch_top #(.NUM_SLOTS(NS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_mask(wr_is_mask),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_is_mask(rd_is_mask),
    .rd_idx(rd_idx), .rd_data(rd_data), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .match(match), .match_idx(match_idx),
    .gen_call(gen_call), .hit_addr(hit_addr), .rw_dir(rw_dir)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] outs();
    return {3'b0, match, match_idx, gen_call, hit_addr, rw_dir};
  endfunction

  // Expected result from the requirements (R3, R4, R5, R6, R7, R8)
  function automatic logic [15:0] model(input logic [7:0] b);
    logic [6:0] a = b[7:1];
    logic m = 1'b0, gc = 1'b0;
    logic [IW-1:0] idx = '0;
    if (a == 7'd0) begin
      for (int i = NS - 1; i >= 0; i--)
        if (addr_m[i][0]) begin m = 1'b1; gc = 1'b1; idx = IW'(i); end
    end else begin
      for (int i = NS - 1; i >= 0; i--)
        if (addr_m[i][7:1] != 7'd0 &&
            ((a ^ addr_m[i][7:1]) & ~mask_m[i][7:1]) == 7'd0) begin
          m = 1'b1; idx = IW'(i);
        end
    end
    return {3'b0, m, idx, gc, (m ? {a, 1'b0} : 8'h00), b[0]};
  endfunction

  task automatic wr(input bit is_mask, input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_is_mask = is_mask; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (is_mask) mask_m[idx] = d & 8'hFE;
    else         addr_m[idx] = d;
  endtask

  // R1 / R2 read-back
  task automatic rd_chk(input bit is_mask, input int idx);
    logic [7:0] e;
    @(negedge clk);
    rd_is_mask = is_mask; rd_idx = IW'(idx);
    @(negedge clk);
    e = is_mask ? mask_m[idx] : addr_m[idx];
    check(rd_data == e, is_mask ? "R2 mask read" : "R1 addr read", {8'h0, rd_data}, {8'h0, e});
  endtask

  // R9: strobe, sample the next cycle, then verify hold
  task automatic strobe_chk(input logic [7:0] b, input string req);
    logic [15:0] e;
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_byte = ~b;
    e = model(b);
    check(outs() == e, req, outs(), e);
    @(negedge clk);
    check(outs() == e, "R9 hold", outs(), e);
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < 256; b++) strobe_chk(8'(b), req);
  endtask

  function automatic logic [7:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  initial begin
    for (int i = 0; i < NS; i++) begin addr_m[i] = '0; mask_m[i] = '0; end
    repeat (3) @(negedge clk);
    // R9 reset values
    check(outs() == 16'h0, "R9 reset outputs", outs(), 16'h0);
    @(negedge clk);
    rst = 1'b0;
    // R10 cleared table
    for (int i = 0; i < NS; i++) begin rd_chk(1'b0, i); rd_chk(1'b1, i); end
    strobe_chk(8'h00, "R10 no gc after reset");
    strobe_chk(8'h41, "R10 no match after reset");

    // Table A: masked range, overlap, gc-only zero slot
    wr(1'b0, 0, 8'h20); wr(1'b1, 0, 8'h07);   // R3 0x10..0x13, R2 mask bit0 dropped
    wr(1'b0, 1, 8'h22); wr(1'b1, 1, 8'h00);   // R4 overlaps slot 0 at 0x11
    wr(1'b0, 2, 8'h01); wr(1'b1, 2, 8'hFF);   // R8 zero field, R5 gc enable
    wr(1'b0, 3, 8'hA1); wr(1'b1, 3, 8'h80);   // R5 second gc enable, 0x10/0x50
    for (int i = 0; i < NS; i++) begin rd_chk(1'b0, i); rd_chk(1'b1, i); end
    strobe_chk(8'h23, "R3 R7 example 0x11 read");
    strobe_chk(8'h26, "R3 example 0x13");
    strobe_chk(8'h28, "R3 outside range 0x14");
    strobe_chk(8'h01, "R5 gc lowest enabled slot");
    strobe_chk(8'hA0, "R4 slot3 only 0x50");
    sweep("R3 R4 R5 R8 table A");

    // Table B: no general-call enable anywhere
    wr(1'b0, 0, 8'h80); wr(1'b1, 0, 8'h00);
    wr(1'b0, 1, 8'h00); wr(1'b1, 1, 8'hFE);
    wr(1'b0, 2, 8'h80); wr(1'b1, 2, 8'h7E);
    wr(1'b0, 3, 8'hFE); wr(1'b1, 3, 8'h00);
    strobe_chk(8'h00, "R5 gc without enable misses");
    sweep("R4 R5 R6 R8 table B");

    // Tables C: pseudo-random contents
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NS; i++) begin wr(1'b0, i, rnd()); wr(1'b1, i, rnd() & 8'h3F); end
      for (int i = 0; i < NS; i++) rd_chk(1'b1, i);
      sweep("R3 R4 R6 R7 random table");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule